// File: doc/BRIEF.md
# Lane-Interleaved Vector Element Sequencer

This block steps one vector arithmetic instruction through a set of parallel lanes. Every lane owns a slice of the 32-entry vector register file, a slice of the element mask, and one pipelined functional unit. Elements are spread over the lanes round-robin: element `i` sits in lane `i mod LANES` at row `i / LANES`. On each beat every lane reads one operand pair from its own slice. The block combines each element's vector-length limit with its mask bit, and the lane pushes the pair into a fixed-latency pipe. The lane writes the result back into its own slice when the result leaves the pipe. An integer add or multiply, truncated to the element width, stands in for the floating-point arithmetic.

A scalar-mode instruction takes element 0 of each source as its operands. Its result is copied into every lane of the destination's first row, which holds elements 0 to LANES-1. A side port writes single elements and the whole mask, and a combinational peek port reads any element. The register and mask write ports are locked out while an instruction is in flight. The next instruction can start in the cycle that `done` is high.

Top module: `vseq_top`

## Requirements
- R1: After reset `busy` and `done` are low and every mask bit is 0, so a masked instruction issued before any mask load writes no element.
- R2: With `op_sel`=0 and `scalar`=0, each destination element `i` below the vector length becomes `src_a[i] + src_b[i]` modulo 2^DW. The result is correct when the destination is also a source.
- R3: With `op_sel`=1, the vector result is `src_a[i] * src_b[i]`, keeping the low DW bits.
- R4: An accepted vector instruction issues ceil(VL/LANES) beats. `busy` is high for beats+LAT cycles after the accepting edge.
- R5: Destination elements at or beyond the vector length keep their old values, including the unused lanes of a partial final beat.
- R6: With `masked`=1, element `i` is written only when `mask_bits[i]` of the last mask load is 1. Element `i` uses bit `i`.
- R7: With `masked`=0, the mask contents have no effect on which elements are written.
- R8: With `scalar`=1, the block computes one result from element 0 of each source and writes it to elements 0..LANES-1 of the destination in a single beat. The mask and the vector length are ignored, and all other elements keep their values.
- R9: A `start` seen while `busy` is high is ignored. The running instruction finishes unchanged and produces exactly one `done`.
- R10: A vector length of 0 issues one beat and writes nothing. A vector length above LANES*DEPTH is treated as LANES*DEPTH.
- R11: Element loads (`ld_we`) and mask loads (`mask_we`) are ignored while `busy` is high.
- R12: `done` is a one-cycle pulse in the cycle after the last write-back edge. `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to accept the instruction on the instruction inputs |
| op_sel | input | 1 | 0 = add, 1 = multiply |
| scalar | input | 1 | Scalar-mode instruction |
| masked | input | 1 | Gate write-back with the mask |
| dst | input | 5 | Destination register |
| src_a | input | 5 | First source register |
| src_b | input | 5 | Second source register |
| vl_in | input | VL_W | Vector length in elements |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle completion pulse |
| ld_we | input | 1 | Write one element (ignored while busy) |
| ld_reg | input | 5 | Register for the element write |
| ld_idx | input | IDX_W | Element index for the element write |
| ld_data | input | DW | Element write data |
| mask_we | input | 1 | Load the whole mask (ignored while busy) |
| mask_bits | input | LANES*DEPTH | Mask value, bit i for element i |
| peek_reg | input | 5 | Register for the element read |
| peek_idx | input | IDX_W | Element index for the element read |
| peek_data | output | DW | Element read data (combinational) |

## Verification
The bench aims at the edges of the lane striping. A partial final beat catches a design that writes the idle lanes or drops the tail element. A vector length of zero and one above the register size catch a miscomputed beat count, which would show up as a wrong `busy` width or writes beyond the register. Scalar instructions issued with the mask set and an odd vector length would expose a design that lets either one leak into replication. Other stimulus targets a `start`, element load or mask load arriving during a run: a design that accepts any of them corrupts the running destination, overwrites a register, or changes the mask seen by the next masked instruction. A destination that aliases its source would reveal a write-back racing ahead of the reads.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    localparam int REG_AW    = 5;
    localparam int NUM_VREGS = 32;

    typedef enum logic {
        FU_ADD = 1'b0,
        FU_MUL = 1'b1
    } fu_op_e;

    typedef struct packed {
        fu_op_e              op;
        logic                scalar;
        logic                masked;
        logic [REG_AW-1:0]   dst;
        logic [REG_AW-1:0]   src_a;
        logic [REG_AW-1:0]   src_b;
    } vinstr_t;

endpackage

// File: rtl/vseq_lane.sv
module vseq_lane
    import vseq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    parameter int LAT   = 3,
    localparam int ROW_W = $clog2(DEPTH),
    localparam int RF_AW = REG_AW + ROW_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RF_AW-1:0] rd_a_addr,
    input  logic [RF_AW-1:0] rd_b_addr,
    output logic [DW-1:0]    rd_a_data,
    output logic [DW-1:0]    rd_b_data,
    input  logic [ROW_W-1:0] mask_row,
    output logic             mask_bit,
    input  logic             issue_en,
    input  fu_op_e           fu_op,
    input  logic [DW-1:0]    opnd_a,
    input  logic [DW-1:0]    opnd_b,
    input  logic [RF_AW-1:0] wb_addr,
    input  logic             ld_we,
    input  logic [RF_AW-1:0] ld_addr,
    input  logic [DW-1:0]    ld_data,
    input  logic             mask_we,
    input  logic [DEPTH-1:0] mask_row_bits,
    input  logic [RF_AW-1:0] peek_addr,
    output logic [DW-1:0]    peek_data
);
    localparam int SLICE = NUM_VREGS * DEPTH;

    logic [DW-1:0]    rf_mem [SLICE];
    logic [DEPTH-1:0] mask_q;
    logic [DW-1:0]    fu_res;
    logic [DW-1:0]    pipe_res [LAT];
    logic [LAT-1:0]   pipe_we;

    assign rd_a_data = rf_mem[rd_a_addr];
    assign rd_b_data = rf_mem[rd_b_addr];
    assign peek_data = rf_mem[peek_addr];
    assign mask_bit  = mask_q[mask_row];

    // stand-in functional unit, truncated to the element width
    always_comb begin
        if (fu_op == FU_MUL) fu_res = opnd_a * opnd_b;
        else                 fu_res = opnd_a + opnd_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_we <= '0;
        end else begin
            pipe_we[0] <= issue_en;
            for (int s = 1; s < LAT; s++) pipe_we[s] <= pipe_we[s-1];
        end
    end

    always_ff @(posedge clk) begin
        pipe_res[0] <= fu_res;
        for (int s = 1; s < LAT; s++) pipe_res[s] <= pipe_res[s-1];
    end

    // write-back has priority; loads are only enabled while idle
    always_ff @(posedge clk) begin
        if (pipe_we[LAT-1])  rf_mem[wb_addr] <= pipe_res[LAT-1];
        else if (ld_we)      rf_mem[ld_addr] <= ld_data;
    end

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q <= mask_row_bits;
    end

endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 4,
    parameter int LAT   = 3,
    localparam int MAXVL  = LANES * DEPTH,
    localparam int VL_W   = $clog2(MAXVL + 1),
    localparam int ROW_W  = $clog2(DEPTH),
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  vinstr_t          instr_in,
    input  logic [VL_W-1:0]  vl_in,
    output logic             busy,
    output logic             done,
    output vinstr_t          cur,
    output logic             issue_v,
    output logic [ROW_W-1:0] issue_row,
    output logic [LANES-1:0] lane_act,
    output logic [ROW_W-1:0] wb_row
);
    logic             busy_q, done_q, issuing_q, accept;
    vinstr_t          cur_q;
    logic [VL_W-1:0]  vl_q, vl_eff;
    logic [ROW_W-1:0] beat_q, last_q, last_nxt;
    logic [LAT-1:0]   pipe_v, pipe_last;
    logic [ROW_W-1:0] pipe_row [LAT];

    assign accept = start && !busy_q;
    assign vl_eff = (vl_in > VL_W'(MAXVL)) ? VL_W'(MAXVL) : vl_in;

    // last beat index = ceil(vl/LANES) - 1, one beat for scalar or empty
    always_comb begin
        if (instr_in.scalar || vl_eff == '0) last_nxt = '0;
        else last_nxt = ROW_W'((vl_eff - 1'b1) >> LANE_W);
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_act[l] = cur_q.scalar || ({1'b0, beat_q, LANE_W'(l)} < vl_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            issuing_q <= 1'b0;
            beat_q    <= '0;
            last_q    <= '0;
            vl_q      <= '0;
            cur_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                cur_q     <= instr_in;
                vl_q      <= vl_eff;
                last_q    <= last_nxt;
                beat_q    <= '0;
                issuing_q <= 1'b1;
                busy_q    <= 1'b1;
            end else if (issuing_q) begin
                if (beat_q == last_q) issuing_q <= 1'b0;
                else                  beat_q    <= beat_q + 1'b1;
            end
            if (pipe_v[LAT-1] && pipe_last[LAT-1]) begin
                done_q <= 1'b1;
                busy_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_v    <= '0;
            pipe_last <= '0;
        end else begin
            pipe_v[0]    <= issuing_q;
            pipe_last[0] <= issuing_q && (beat_q == last_q);
            for (int s = 1; s < LAT; s++) begin
                pipe_v[s]    <= pipe_v[s-1];
                pipe_last[s] <= pipe_last[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        pipe_row[0] <= beat_q;
        for (int s = 1; s < LAT; s++) pipe_row[s] <= pipe_row[s-1];
    end

    assign busy      = busy_q;
    assign done      = done_q;
    assign cur       = cur_q;
    assign issue_v   = issuing_q;
    assign issue_row = beat_q;
    assign wb_row    = pipe_row[LAT-1];

endmodule

// File: rtl/vseq_top.sv
module vseq_top
    import vseq_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    parameter int LAT   = 3,
    localparam int MAXVL  = LANES * DEPTH,
    localparam int IDX_W  = $clog2(MAXVL),
    localparam int VL_W   = $clog2(MAXVL + 1),
    localparam int ROW_W  = $clog2(DEPTH),
    localparam int LANE_W = $clog2(LANES),
    localparam int RF_AW  = REG_AW + ROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_sel,
    input  logic              scalar,
    input  logic              masked,
    input  logic [4:0]        dst,
    input  logic [4:0]        src_a,
    input  logic [4:0]        src_b,
    input  logic [VL_W-1:0]   vl_in,
    output logic              busy,
    output logic              done,
    input  logic              ld_we,
    input  logic [4:0]        ld_reg,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [DW-1:0]     ld_data,
    input  logic              mask_we,
    input  logic [MAXVL-1:0]  mask_bits,
    input  logic [4:0]        peek_reg,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic [DW-1:0]     peek_data
);
    vinstr_t          instr_in, cur;
    logic             issue_v;
    logic [ROW_W-1:0] issue_row, wb_row;
    logic [LANES-1:0] lane_act;
    logic [DW-1:0]    rd_a [LANES];
    logic [DW-1:0]    rd_b [LANES];
    logic [DW-1:0]    peek_arr [LANES];
    logic [LANES-1:0] mask_bit;
    logic [DEPTH-1:0] mask_rows [LANES];

    assign instr_in = '{op: fu_op_e'(op_sel), scalar: scalar, masked: masked,
                        dst: dst, src_a: src_a, src_b: src_b};

    vseq_ctrl #(.LANES(LANES), .DEPTH(DEPTH), .LAT(LAT)) ctrl_i (
        .clk(clk), .rst(rst), .start(start), .instr_in(instr_in), .vl_in(vl_in),
        .busy(busy), .done(done), .cur(cur), .issue_v(issue_v),
        .issue_row(issue_row), .lane_act(lane_act), .wb_row(wb_row)
    );

    // element i of the mask goes to lane i mod LANES, row i / LANES
    always_comb begin
        for (int l = 0; l < LANES; l++)
            for (int r = 0; r < DEPTH; r++)
                mask_rows[l][r] = mask_bits[r*LANES + l];
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [DW-1:0] op_a, op_b;
            logic          wr_en;
            logic          ld_hit;

            // scalar mode: every lane takes lane 0's element 0
            assign op_a   = cur.scalar ? rd_a[0] : rd_a[g];
            assign op_b   = cur.scalar ? rd_b[0] : rd_b[g];
            assign wr_en  = issue_v && lane_act[g] &&
                            (cur.scalar || !cur.masked || mask_bit[g]);
            assign ld_hit = ld_we && !busy && (ld_idx[LANE_W-1:0] == LANE_W'(g));

            vseq_lane #(.DEPTH(DEPTH), .DW(DW), .LAT(LAT)) lane_i (
                .clk(clk), .rst(rst),
                .rd_a_addr({cur.src_a, issue_row}),
                .rd_b_addr({cur.src_b, issue_row}),
                .rd_a_data(rd_a[g]), .rd_b_data(rd_b[g]),
                .mask_row(issue_row), .mask_bit(mask_bit[g]),
                .issue_en(wr_en), .fu_op(cur.op),
                .opnd_a(op_a), .opnd_b(op_b),
                .wb_addr({cur.dst, wb_row}),
                .ld_we(ld_hit), .ld_addr({ld_reg, ld_idx[IDX_W-1:LANE_W]}),
                .ld_data(ld_data),
                .mask_we(mask_we && !busy), .mask_row_bits(mask_rows[g]),
                .peek_addr({peek_reg, peek_idx[IDX_W-1:LANE_W]}),
                .peek_data(peek_arr[g])
            );
        end
    endgenerate

    assign peek_data = peek_arr[peek_idx[LANE_W-1:0]];

endmodule

// File: rtl/vseq_chk.sv
module vseq_chk
    import vseq_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    start,
    input logic    busy,
    input logic    done,
    input logic    issue_v,
    input vinstr_t cur
);
    // R9
    refused_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (cur == $past(cur)));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R12
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R4
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R4
    issue_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        issue_v |-> busy);

endmodule

bind vseq_top vseq_chk chk_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .issue_v(issue_v), .cur(cur)
);

// File: tb/vseq_top_tb_top.sv
module vseq_top_tb_top;
    localparam int LANES = 4;
    localparam int DEPTH = 4;
    localparam int DW    = 16;
    localparam int LAT   = 3;
    localparam int MAXVL = LANES * DEPTH;
    localparam int IDX_W = $clog2(MAXVL);
    localparam int VL_W  = $clog2(MAXVL + 1);

    logic clk = 1'b0;
    logic rst, start, op_sel, scalar, masked, ld_we, mask_we;
    logic [4:0] dst, src_a, src_b, ld_reg, peek_reg;
    logic [VL_W-1:0] vl_in;
    logic [IDX_W-1:0] ld_idx, peek_idx;
    logic [DW-1:0] ld_data, peek_data;
    logic [MAXVL-1:0] mask_bits;
    logic busy, done;

    int checks = 0;
    int fails  = 0;
    int mdl [32][MAXVL];
    bit mmask [MAXVL];

    always #4 clk = ~clk;

    vseq_top #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW), .LAT(LAT)) dut_i (
        .clk(clk), .rst(rst), .start(start), .op_sel(op_sel), .scalar(scalar),
        .masked(masked), .dst(dst), .src_a(src_a), .src_b(src_b), .vl_in(vl_in),
        .busy(busy), .done(done), .ld_we(ld_we), .ld_reg(ld_reg), .ld_idx(ld_idx),
        .ld_data(ld_data), .mask_we(mask_we), .mask_bits(mask_bits),
        .peek_reg(peek_reg), .peek_idx(peek_idx), .peek_data(peek_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int fu(input int op, input int x, input int y);
        return op ? ((x * y) & 16'hFFFF) : ((x + y) & 16'hFFFF);
    endfunction

    task automatic load_elem(input int r, input int i, input int v);
        @(negedge clk);
        ld_we = 1'b1; ld_reg = 5'(r); ld_idx = IDX_W'(i); ld_data = DW'(v);
        @(negedge clk);
        ld_we = 1'b0;
        mdl[r][i] = v & 16'hFFFF;
    endtask

    task automatic load_mask(input logic [MAXVL-1:0] bits);
        @(negedge clk);
        mask_we = 1'b1; mask_bits = bits;
        @(negedge clk);
        mask_we = 1'b0;
        for (int i = 0; i < MAXVL; i++) mmask[i] = bits[i];
    endtask

    task automatic check_reg(input string tag, input int r);
        for (int i = 0; i < MAXVL; i++) begin
            peek_reg = 5'(r); peek_idx = IDX_W'(i);
            #1;
            chk(tag, int'(peek_data), mdl[r][i]);
        end
    endtask

    // issue one instruction, predict its effect, check busy/done every cycle
    task automatic run(input int op, input int sc, input int mk, input int d,
                       input int a, input int b, input int vl, input int poke);
        int sa [MAXVL];
        int sb [MAXVL];
        int vle, nb, res;
        vle = (vl > MAXVL) ? MAXVL : vl;
        nb  = sc ? 1 : ((vle == 0) ? 1 : (vle + LANES - 1) / LANES);
        for (int i = 0; i < MAXVL; i++) begin sa[i] = mdl[a][i]; sb[i] = mdl[b][i]; end
        if (sc) begin
            res = fu(op, sa[0], sb[0]);
            for (int i = 0; i < LANES; i++) mdl[d][i] = res;
        end else begin
            for (int i = 0; i < vle; i++)
                if (!mk || mmask[i]) mdl[d][i] = fu(op, sa[i], sb[i]);
        end
        @(negedge clk);
        op_sel = op[0]; scalar = sc[0]; masked = mk[0];
        dst = 5'(d); src_a = 5'(a); src_b = 5'(b); vl_in = VL_W'(vl);
        start = 1'b1;
        for (int k = 1; k <= nb + LAT + 2; k++) begin
            @(negedge clk);
            chk("R4 busy width", int'(busy), (k <= nb + LAT) ? 1 : 0);
            chk("R12 done pulse", int'(done), (k == nb + LAT + 1) ? 1 : 0);
            if (k == 1) begin
                if (poke) begin
                    dst = 5'(d + 1); src_a = 5'(b); op_sel = ~op_sel; vl_in = VL_W'(3);
                    ld_we = 1'b1; ld_reg = 5'd31; ld_idx = '0; ld_data = 16'hBEEF;
                    mask_we = 1'b1; mask_bits = '0;
                end else begin
                    start = 1'b0;
                end
            end
            if (k == 3) begin
                start = 1'b0; ld_we = 1'b0; mask_we = 1'b0;
            end
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; op_sel = 1'b0; scalar = 1'b0; masked = 1'b0;
        dst = '0; src_a = '0; src_b = '0; vl_in = '0;
        ld_we = 1'b0; ld_reg = '0; ld_idx = '0; ld_data = '0;
        mask_we = 1'b0; mask_bits = '0; peek_reg = '0; peek_idx = '0;
        for (int i = 0; i < MAXVL; i++) mmask[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 done after reset", int'(done), 0);

        for (int r = 0; r <= 10; r++)
            for (int i = 0; i < MAXVL; i++)
                load_elem(r, i, r * 977 + i * 131 + 7);
        for (int i = 0; i < MAXVL; i++) load_elem(31, i, 500 + i);

        // R1: mask is clear after reset, masked add writes nothing
        run(0, 0, 1, 9, 1, 2, 16, 0);
        check_reg("R1 cleared mask", 9);

        run(0, 0, 0, 5, 1, 2, 16, 0);
        check_reg("R2 vector add", 5);

        run(1, 0, 0, 6, 3, 4, 16, 0);
        check_reg("R3 vector multiply", 6);

        run(0, 0, 0, 7, 1, 3, 7, 0);
        check_reg("R5 partial beat vl=7", 7);
        run(1, 0, 0, 7, 2, 4, 5, 0);
        check_reg("R5 partial beat vl=5", 7);

        load_mask(16'hA5C3);
        run(0, 0, 1, 8, 4, 5, 16, 0);
        check_reg("R6 masked add", 8);

        run(1, 0, 0, 9, 5, 6, 16, 0);
        check_reg("R7 mask ignored when unmasked", 9);

        run(1, 1, 1, 10, 1, 2, 9, 0);
        check_reg("R8 scalar replication", 10);

        // R9 / R11: start, element load and mask load during a run
        run(0, 0, 1, 0, 3, 4, 16, 1);
        check_reg("R9 running instruction intact", 0);
        check_reg("R9 refused destination untouched", 1);
        check_reg("R11 load while busy ignored", 31);
        run(0, 0, 1, 2, 5, 6, 16, 0);
        check_reg("R11 mask kept across busy load", 2);

        run(0, 0, 0, 3, 1, 2, 0, 0);
        check_reg("R10 zero length writes nothing", 3);
        run(1, 0, 0, 4, 5, 6, 20, 0);
        check_reg("R10 length clamped", 4);

        run(0, 0, 0, 1, 1, 1, 13, 0);
        check_reg("R2 destination aliases source", 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule